// File: doc/BRIEF.md
# Address Parity Flash Pattern Tester

This block is a built-in test sequencer for a flash-style memory. It drives a simple memory port made of read, program and whole-chip erase requests, an address bus and a write data bus. The memory answers every request with a ready signal. The test exercises each cell with a data pattern that depends only on the cell's address: every data bit of a cell equals the XOR of all of its row and column address bits. A cell whose address holds an odd number of ones therefore gets the opposite word of any cell whose address differs from it in exactly one bit.

A `start` pulse runs the whole test. The block first erases the device. It then programs the parity pattern into every cell and reads every cell back to compare it. It erases the device a second time, programs the complemented pattern and reads it back again. Flash programming can only clear bits, so each programmed pass must start from an erased array. The test therefore uses exactly two erases and 4N program or read operations for N cells. The block keeps a sticky fail flag, captures the first mismatch (address, expected word and word read) and raises `done` at the end.

If a single address-decoder bit fails, two cells that should hold opposite words share one physical location. Programming both of them leaves the AND of the two words in that location, so at least one of the two reads mismatches.

Top module: `parity_flash_tester`

## Requirements
- R1: After reset, all three memory requests, `busy`, `done` and `fail` are low.
- R2: The cell address is {row, column}, with the row in the upper bits. In the first programmed pass every bit of `mem_wdata` equals the XOR of all address bits, XORed with the parameter `ONES_ON_EVEN`. In the second pass each word is the bitwise complement of the first-pass word for the same address.
- R3: The operation order is fixed: one erase, then programs at addresses 0 to N-1 in ascending order, then reads at addresses 0 to N-1, then one erase, then complemented programs at 0 to N-1, then reads at 0 to N-1. That is 4N programs or reads and exactly two erases.
- R4: At most one of `mem_rd`, `mem_prog` and `mem_erase` is high in any cycle.
- R5: While a request is high and `mem_ready` is low, the request, `mem_addr` and `mem_wdata` hold their values. The sequencer advances only in a cycle where `mem_ready` is high.
- R6: A read whose `mem_rdata` differs from the expected word sets `fail`. The first such mismatch captures `fail_addr`, `fail_exp` and `fail_got`. Later mismatches change none of them, and the test runs on to the end.
- R7: After the last read, `done` goes high, `busy` goes low and no request is issued. This state holds until the next `start`.
- R8: A `start` pulse while `busy` is high has no effect on the operation sequence.
- R9: A single address bit that the memory ignores, or a stuck data bit, is reported as a failure with the first mismatching address and both data words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a test when the block is idle or done |
| mem_rd | output | 1 | Read request |
| mem_prog | output | 1 | Program request (can only clear bits) |
| mem_erase | output | 1 | Whole-chip erase request (sets all bits) |
| mem_addr | output | ROW_W+COL_W | Cell address {row, column} |
| mem_wdata | output | DATA_W | Program data |
| mem_rdata | input | DATA_W | Read data, valid when mem_ready is high during a read |
| mem_ready | input | 1 | Completes the pending request in this cycle |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished |
| fail | output | 1 | At least one read mismatched |
| fail_addr | output | ROW_W+COL_W | Address of the first mismatch |
| fail_exp | output | DATA_W | Expected word at the first mismatch |
| fail_got | output | DATA_W | Word read at the first mismatch |

## Verification
The assertions check the memory-port rules on every cycle:
- no two requests are high together;
- a request, its address and its data hold steady until ready;
- once `fail` is set, it and the captured mismatch record stay unchanged until the next start;
- no request is issued while `done` is high.

Only the bench scenarios can show the rest, because they need a memory model and a reference: the exact order of operations, the parity and complemented data words, the count of two erases, the capture of the first mismatch under an aliased address bit or a stuck data bit, and the fact that a start pulse during a run is ignored.

// File: rtl/parity_flash_tester.sv
module parity_flash_tester #(
  parameter int ROW_W = 3,
  parameter int COL_W = 3,
  parameter int DATA_W = 8,
  parameter bit ONES_ON_EVEN = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  output logic                   mem_rd,
  output logic                   mem_prog,
  output logic                   mem_erase,
  output logic [ROW_W+COL_W-1:0] mem_addr,
  output logic [DATA_W-1:0]      mem_wdata,
  input  logic [DATA_W-1:0]      mem_rdata,
  input  logic                   mem_ready,
  output logic                   busy,
  output logic                   done,
  output logic                   fail,
  output logic [ROW_W+COL_W-1:0] fail_addr,
  output logic [DATA_W-1:0]      fail_exp,
  output logic [DATA_W-1:0]      fail_got
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam logic [ADDR_W-1:0] LAST = '1;

  typedef enum logic [2:0] {S_IDLE, S_ERASE, S_PROG, S_READ, S_DONE} state_t;

  state_t            st;
  logic              pass2;
  logic [ADDR_W-1:0] addr;

  wire par = (^addr) ^ pass2 ^ ONES_ON_EVEN;
  wire [DATA_W-1:0] pattern = {DATA_W{par}};
  wire miss = (st == S_READ) && mem_ready && (mem_rdata != pattern);
  wire at_last = (addr == LAST);

  assign mem_addr  = addr;
  assign mem_wdata = pattern;
  assign mem_erase = (st == S_ERASE);
  assign mem_prog  = (st == S_PROG);
  assign mem_rd    = (st == S_READ);
  assign busy      = mem_erase | mem_prog | mem_rd;
  assign done      = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      pass2     <= 1'b0;
      addr      <= '0;
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_got  <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: begin
          if (start) begin
            st        <= S_ERASE;
            pass2     <= 1'b0;
            addr      <= '0;
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_exp  <= '0;
            fail_got  <= '0;
          end
        end
        S_ERASE: begin
          if (mem_ready) begin
            st   <= S_PROG;
            addr <= '0;
          end
        end
        S_PROG: begin
          if (mem_ready) begin
            addr <= addr + ADDR_W'(1);
            if (at_last) st <= S_READ;
          end
        end
        S_READ: begin
          if (mem_ready) begin
            addr <= addr + ADDR_W'(1);
            if (miss && !fail) begin
              fail      <= 1'b1;
              fail_addr <= addr;
              fail_exp  <= pattern;
              fail_got  <= mem_rdata;
            end
            if (at_last) begin
              if (pass2) begin
                st <= S_DONE;
              end else begin
                st    <= S_ERASE;
                pass2 <= 1'b1;
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module parity_flash_tester_chk #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          mem_rd,
  input logic          mem_prog,
  input logic          mem_erase,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ready,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic [AW-1:0] fail_addr,
  input logic [DW-1:0] fail_exp,
  input logic [DW-1:0] fail_got
);
  assert_one_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_prog, mem_erase}));

  assert_hold_until_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_wdata) &&
      $stable(mem_rd) && $stable(mem_prog) && $stable(mem_erase)));

  assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail);

  assert_first_miss_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> ($stable(fail_addr) && $stable(fail_exp) && $stable(fail_got)));

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_rd && !mem_prog && !mem_erase && !busy));

  assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

bind parity_flash_tester parity_flash_tester_chk #(.AW(ROW_W + COL_W), .DW(DATA_W)) chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_rd(mem_rd), .mem_prog(mem_prog),
  .mem_erase(mem_erase), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ready(mem_ready), .busy(busy), .done(done), .fail(fail),
  .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_got(fail_got));

// File: tb/parity_flash_tester_test.sv
module parity_flash_tester_test;
  localparam int RW = 3, CW = 3, DW = 8, AW = RW + CW, N = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic mem_rd, mem_prog, mem_erase, mem_ready, busy, done, fail;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, fail_exp, fail_got;

  always #4 clk = ~clk;

  parity_flash_tester #(.ROW_W(RW), .COL_W(CW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_rd(mem_rd), .mem_prog(mem_prog),
    .mem_erase(mem_erase), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .busy(busy), .done(done),
    .fail(fail), .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_got(fail_got));

  int compared = 0, mismatched = 0, cycles = 0;
  int fault = 0;

  // memory model: programming ANDs, erase sets all ones
  logic [DW-1:0] cells [N];
  int lat_cnt = 0, op_cnt = 0;
  wire req = mem_rd | mem_prog | mem_erase;
  assign mem_ready = req && (lat_cnt >= (op_cnt % 3));

  function automatic logic [AW-1:0] phys(logic [AW-1:0] a);
    return (fault == 1) ? (a & ~AW'(8)) : a;
  endfunction

  function automatic logic [DW-1:0] stuck(logic [AW-1:0] p, logic [DW-1:0] v);
    return (fault == 2 && p == AW'(5)) ? (v | DW'(1)) : v;
  endfunction

  always_comb mem_rdata = stuck(phys(mem_addr), cells[phys(mem_addr)]);

  always @(posedge clk) begin
    if (req && mem_ready) begin
      if (mem_erase) for (int i = 0; i < N; i++) cells[i] <= '1;
      else if (mem_prog) cells[phys(mem_addr)] <= cells[phys(mem_addr)] & mem_wdata;
      lat_cnt <= 0;
      op_cnt  <= op_cnt + 1;
    end else if (req) lat_cnt <= lat_cnt + 1;
  end

  typedef struct {int kind; logic [AW-1:0] addr; logic [DW-1:0] data;} item_t;
  item_t exp_q[$];
  logic          e_fail;
  logic [AW-1:0] e_addr;
  logic [DW-1:0] e_exp, e_got;

  function automatic logic [DW-1:0] pat(logic [AW-1:0] a, bit p);
    return {DW{(^a) ^ p}};
  endfunction

  task automatic check(bit ok, string req_tag, string what, longint act, longint expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, expv);
    end
  endtask

  // driver: pushes expected operations and computes the expected outcome
  task automatic push_run();
    logic [DW-1:0] sh [N];
    e_fail = 0; e_addr = '0; e_exp = '0; e_got = '0;
    for (int p = 0; p < 2; p++) begin
      exp_q.push_back('{0, '0, '0});
      for (int i = 0; i < N; i++) sh[i] = '1;
      for (int a = 0; a < N; a++) begin
        exp_q.push_back('{1, AW'(a), pat(AW'(a), p[0])});
        sh[phys(AW'(a))] = sh[phys(AW'(a))] & pat(AW'(a), p[0]);
      end
      for (int a = 0; a < N; a++) begin
        logic [DW-1:0] g;
        exp_q.push_back('{2, AW'(a), pat(AW'(a), p[0])});
        g = stuck(phys(AW'(a)), sh[phys(AW'(a))]);
        if (g != pat(AW'(a), p[0]) && !e_fail) begin
          e_fail = 1; e_addr = AW'(a); e_exp = pat(AW'(a), p[0]); e_got = g;
        end
      end
    end
  endtask

  // monitor: R2 data words, R3 order and count
  always @(negedge clk) begin
    if (rst_n && req && mem_ready) begin
      int k;
      k = mem_erase ? 0 : (mem_prog ? 1 : 2);
      if (exp_q.size() == 0) check(0, "R3", "unexpected operation", k, -1);
      else begin
        item_t it;
        it = exp_q.pop_front();
        check(k == it.kind, "R3", "operation kind", k, it.kind);
        if (it.kind != 0) check(mem_addr == it.addr, "R3", "address", mem_addr, it.addr);
        if (it.kind == 1) check(mem_wdata == it.data, "R2", "program word", mem_wdata, it.data);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run(int f, bit poke);
    fault = f;
    push_run();
    pulse_start();
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;  // R8: ignored mid-run
    end
    while (!done) @(negedge clk);
    check(exp_q.size() == 0, "R3", "leftover operations", exp_q.size(), 0);
    check(!busy, "R7", "busy at done", busy, 0);
    check(fail == e_fail, (f == 0) ? "R6" : "R9", "fail flag", fail, e_fail);
    if (e_fail) begin
      check(fail_addr == e_addr, "R9", "fail_addr", fail_addr, e_addr);
      check(fail_exp == e_exp, "R6", "fail_exp", fail_exp, e_exp);
      check(fail_got == e_got, "R6", "fail_got", fail_got, e_got);
    end
    repeat (5) @(negedge clk);
    check(done && !req, "R7", "done held quietly", {done, req}, 2);
  endtask

  initial begin
    for (int i = 0; i < N; i++) cells[i] = 8'h5A;
    repeat (3) @(negedge clk);
    check(!mem_rd && !mem_prog && !mem_erase && !busy && !done && !fail,
          "R1", "reset outputs", {mem_rd, mem_prog, mem_erase, busy, done, fail}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done, "R1", "idle after reset", {busy, done}, 0);
    run(0, 1'b0);
    run(0, 1'b1);
    run(1, 1'b0);
    run(2, 1'b0);
    run(0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule